// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block sits in the execute stage of a small 32-bit processor and handles three system instructions: environment call, breakpoint and machine return. The trap status registers have no storage of their own here. They are addresses in the same 6-bit space as the general registers. Taking a trap therefore means a run of writes through the one register-file write port. The block saves the faulting PC, then the cause code, then a zeroed trap value, one per clock. It then raises a one-cycle completion strobe with the handler address.

A return instruction writes nothing. It completes in the cycle after it is accepted, and the new PC comes from operand A. Decode offers an instruction with `dec_valid` and a 2-bit kind. The sequencer takes it only while idle. While a sequence is in progress, `busy` tells decode to hold off.

Top module: `trap_seq`

## Requirements
- R1: A synchronous active-high reset, applied in any state, leaves `wr_en`, `done` and `busy` low in the cycle after the reset edge.
- R2: An instruction is accepted on a clock edge where `dec_valid` is high, the block is idle and `dec_kind` is 1 (environment call) or 2 (breakpoint). The block then writes exactly three times, in the three cycles after acceptance. The address order is fixed: `EPC_ADDR` (default 6'h21), then `CAUSE_ADDR` (default 6'h22), then `TVAL_ADDR` (default 6'h23).
- R3: The data of the `EPC_ADDR` write equals `cur_pc` as sampled at acceptance.
- R4: The data of the `CAUSE_ADDR` write is 11 for an environment call and 3 for a breakpoint.
- R5: The data of the `TVAL_ADDR` write is zero for both trap kinds.
- R6: After a trap, `done` is high for exactly one cycle: the fourth cycle after acceptance, right after the last write. In that cycle `pc_next` equals `trap_base[31:2]` sampled at acceptance, with bits [1:0] zero. No write happens while `done` is high.
- R7: An accepted return (`dec_kind` = 3) makes no write. It raises `done` in the cycle after acceptance, with `pc_next` = {`opnd_a[31:2]`, 2'b00}. The value of `opnd_b` has no effect.
- R8: While `busy` is high, `dec_valid` and the decode inputs are ignored. They start no new writes, cause no second `done`, and do not change `pc_next`.
- R9: A `dec_valid` with `dec_kind` = 0 is ignored. It causes no write and no `done`.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. It is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decoded instruction offered |
| dec_kind | input | 2 | 0 none, 1 environment call, 2 breakpoint, 3 return |
| cur_pc | input | 32 | PC of the offered instruction |
| opnd_a | input | 32 | Return base address |
| opnd_b | input | 32 | Second operand, unused (zero by convention) |
| trap_base | input | 32 | Trap handler base (machine trap vector) |
| wr_en | output | 1 | Register-file write enable |
| wr_addr | output | 6 | Register-file write address |
| wr_data | output | 32 | Register-file write data |
| pc_next | output | 32 | Redirect PC, valid while `done` is high |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Sequence in progress; new instructions are not taken |

## Verification
A wrong state ordering shows up at the write port within one to three cycles of acceptance. It appears as a missing, doubled or reordered address, or as a `done` strobe one cycle early or late. A wrongly captured PC, cause code or base address is visible as soon as the matching write or the `done` cycle comes out. A decode request that leaks into a busy sequencer shows up later, as a fourth write or a second strobe a few cycles after the first.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int XLEN_DEF = 32;
    localparam int AW_DEF   = 6;

    typedef enum logic [1:0] {
        OPK_NONE   = 2'd0,
        OPK_ECALL  = 2'd1,
        OPK_EBREAK = 2'd2,
        OPK_MRET   = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EPC,
        ST_CAUSE,
        ST_TVAL,
        ST_DONE
    } seq_state_t;

    localparam logic [4:0] CODE_BREAK = 5'd3;
    localparam logic [4:0] CODE_ECALL = 5'd11;

    function automatic logic [4:0] cause_code(input op_kind_t k);
        return (k == OPK_EBREAK) ? CODE_BREAK : CODE_ECALL;
    endfunction

    function automatic logic is_trap(input op_kind_t k);
        return (k == OPK_ECALL) || (k == OPK_EBREAK);
    endfunction

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
    import trap_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_valid,
    input  op_kind_t   dec_kind,
    output seq_state_t state,
    output logic       accept
);
    seq_state_t state_q, state_d;

    assign accept = dec_valid && (state_q == ST_IDLE) && (dec_kind != OPK_NONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = is_trap(dec_kind) ? ST_EPC : ST_DONE;
            ST_EPC:   state_d = ST_CAUSE;
            ST_CAUSE: state_d = ST_TVAL;
            ST_TVAL:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    p_epc_to_cause_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_EPC |=> state_q == ST_CAUSE);
    p_cause_to_tval_r2: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_CAUSE |=> state_q == ST_TVAL);
    p_tval_to_done_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_TVAL |=> state_q == ST_DONE);
    p_done_to_idle_r10: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DONE |=> state_q == ST_IDLE);
endmodule

// File: rtl/trap_seq_ctx.sv
module trap_seq_ctx
    import trap_seq_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  op_kind_t        dec_kind,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] trap_base,
    output logic [XLEN-1:0] saved_pc,
    output logic [XLEN-1:0] target,
    output op_kind_t        saved_kind
);
    logic [XLEN-1:0] src;

    assign src = is_trap(dec_kind) ? trap_base : opnd_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_pc   <= '0;
            target     <= '0;
            saved_kind <= OPK_NONE;
        end else if (accept) begin
            saved_pc   <= cur_pc;
            target     <= {src[XLEN-1:2], 2'b00};
            saved_kind <= dec_kind;
        end
    end
endmodule

// File: rtl/trap_seq_wport.sv
module trap_seq_wport
    import trap_seq_pkg::*;
#(
    parameter int             XLEN       = XLEN_DEF,
    parameter int             AW         = AW_DEF,
    parameter logic [AW-1:0]  EPC_ADDR   = 6'h21,
    parameter logic [AW-1:0]  CAUSE_ADDR = 6'h22,
    parameter logic [AW-1:0]  TVAL_ADDR  = 6'h23
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_t      state,
    input  op_kind_t        saved_kind,
    input  logic [XLEN-1:0] saved_pc,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [XLEN-1:0] wr_data
);
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        unique case (state)
            ST_EPC: begin
                wr_en   = 1'b1;
                wr_addr = EPC_ADDR;
                wr_data = saved_pc;
            end
            ST_CAUSE: begin
                wr_en   = 1'b1;
                wr_addr = CAUSE_ADDR;
                wr_data = {{(XLEN-5){1'b0}}, cause_code(saved_kind)};
            end
            ST_TVAL: begin
                wr_en   = 1'b1;
                wr_addr = TVAL_ADDR;
                wr_data = '0;
            end
            default: ;
        endcase
    end

    p_cause_value_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CAUSE_ADDR) |->
        (wr_data == XLEN'(3) || wr_data == XLEN'(11)));
    p_tval_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == TVAL_ADDR) |-> wr_data == '0);
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int             XLEN       = XLEN_DEF,
    parameter int             AW         = AW_DEF,
    parameter logic [AW-1:0]  EPC_ADDR   = 6'h21,
    parameter logic [AW-1:0]  CAUSE_ADDR = 6'h22,
    parameter logic [AW-1:0]  TVAL_ADDR  = 6'h23
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dec_valid,
    input  logic [1:0]      dec_kind,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] trap_base,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] pc_next,
    output logic            done,
    output logic            busy
);
    seq_state_t      state;
    logic            accept;
    op_kind_t        kind_in, saved_kind;
    logic [XLEN-1:0] saved_pc;
    logic            unused_b;

    assign kind_in  = op_kind_t'(dec_kind);
    assign unused_b = ^opnd_b;

    trap_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_kind(kind_in),
        .state(state), .accept(accept)
    );

    trap_seq_ctx #(.XLEN(XLEN)) u_ctx (
        .clk(clk), .rst(rst), .accept(accept), .dec_kind(kind_in),
        .cur_pc(cur_pc), .opnd_a(opnd_a), .trap_base(trap_base),
        .saved_pc(saved_pc), .target(pc_next), .saved_kind(saved_kind)
    );

    trap_seq_wport #(
        .XLEN(XLEN), .AW(AW), .EPC_ADDR(EPC_ADDR),
        .CAUSE_ADDR(CAUSE_ADDR), .TVAL_ADDR(TVAL_ADDR)
    ) u_wport (
        .clk(clk), .rst(rst), .state(state), .saved_kind(saved_kind),
        .saved_pc(saved_pc), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign done = (state == ST_DONE);
    assign busy = (state != ST_IDLE);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!wr_en && !done && !busy));
    p_epc_is_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == EPC_ADDR) |-> wr_data == $past(cur_pc));
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_no_write_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);
    p_target_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> pc_next[1:0] == 2'b00);
    p_busy_target_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(pc_next));
    p_none_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && dec_valid && dec_kind == 2'd0) |=> !busy);
endmodule

// File: tb/trap_seq_tb.sv
`timescale 1ns/1ps
module trap_seq_tb;
    localparam logic [5:0] A_EPC = 6'h21, A_CAUSE = 6'h22, A_TVAL = 6'h23;
    localparam int NV = 6;
    localparam logic [1:0]  V_KIND [NV] = '{2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd1};
    localparam logic [31:0] V_PC   [NV] = '{32'h0000_1000, 32'h8000_0ffc, 32'h0000_0100,
                                            32'h0000_0200, 32'h0000_0300, 32'hffff_fffc};
    localparam logic [31:0] V_A    [NV] = '{32'h1234_5677, 32'h0, 32'h0000_4447,
                                            32'hdead_beee, 32'h1, 32'hffff_ffff};
    localparam logic [31:0] V_B    [NV] = '{32'h0, 32'h0, 32'h0, 32'hffff_ffff, 32'h0, 32'h5};
    localparam logic [31:0] V_BASE [NV] = '{32'h0000_8003, 32'hffff_ff01, 32'h0000_8000,
                                            32'h0, 32'h40, 32'h0};

    logic        clk = 1'b0, rst = 1'b1, dec_valid = 1'b0;
    logic [1:0]  dec_kind = 2'd0;
    logic [31:0] cur_pc = '0, opnd_a = '0, opnd_b = '0, trap_base = '0;
    logic        wr_en, done, busy;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data, pc_next;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    trap_seq u_dut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .cur_pc(cur_pc), .opnd_a(opnd_a), .opnd_b(opnd_b), .trap_base(trap_base),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pc_next(pc_next), .done(done), .busy(busy)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Offer one instruction and watch six cycles. With hold set, dec_valid stays
    // high while busy and the decode inputs are changed (R8).
    task automatic run(input logic [1:0] k, input logic [31:0] pc, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] base, input logic hold);
        logic        trap = (k == 2'd1) || (k == 2'd2);
        int          dcyc = trap ? 4 : (k == 2'd3 ? 1 : 0);
        logic [31:0] tgt  = trap ? {base[31:2], 2'b00} : {a[31:2], 2'b00};
        logic [5:0]  ea [3] = '{A_EPC, A_CAUSE, A_TVAL};
        logic [31:0] ed [3];
        int          nwr = 0, ndone = 0;
        ed[0] = pc; ed[1] = (k == 2'd2) ? 32'd3 : 32'd11; ed[2] = 32'd0;
        @(negedge clk);
        dec_valid = 1'b1; dec_kind = k; cur_pc = pc; opnd_a = a; opnd_b = b; trap_base = base;
        @(posedge clk);
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (c == 1 && hold) begin
                dec_kind = 2'd3; opnd_a = 32'hffff_fff0; trap_base = 32'h1111_1110;
            end
            if ((c == 1 && !hold) || c == 5) dec_valid = 1'b0;
            if (wr_en) begin
                if (nwr < 3) begin
                    chk(trap && c == nwr + 1, "R2 write cycle", c, nwr + 1);
                    chk(wr_addr == ea[nwr], "R2 write address order", {26'd0, wr_addr}, {26'd0, ea[nwr]});
                    if (nwr == 0) chk(wr_data == ed[0], "R3 saved pc", wr_data, ed[0]);
                    if (nwr == 1) chk(wr_data == ed[1], "R4 cause code", wr_data, ed[1]);
                    if (nwr == 2) chk(wr_data == ed[2], "R5 trap value zero", wr_data, ed[2]);
                end
                nwr++;
            end
            if (done) begin
                ndone++;
                chk(pc_next == tgt, trap ? "R6 trap target" : "R7 return target", pc_next, tgt);
            end
            chk(done == (c == dcyc), trap ? "R6 done timing" : (k == 2'd3 ? "R7 done timing" : "R9 no done"),
                {31'd0, done}, {31'd0, c == dcyc});
            chk(busy == (c <= dcyc), "R10 busy window", {31'd0, busy}, {31'd0, c <= dcyc});
        end
        chk(nwr == (trap ? 3 : 0), trap ? "R2 write count" : (k == 2'd3 ? "R7 no writes" : "R9 no writes"),
            nwr, trap ? 3 : 0);
        chk(ndone == (dcyc != 0 ? 1 : 0), hold ? "R8 single done while held" : "R6 single done",
            ndone, dcyc != 0 ? 1 : 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!wr_en && !done && !busy, "R1 reset state", {29'd0, wr_en, done, busy}, 32'd0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) run(V_KIND[i], V_PC[i], V_A[i], V_B[i], V_BASE[i], 1'b0);
        // R8: valid held high and inputs changed during a breakpoint sequence
        run(2'd2, 32'h0000_2468, 32'h0, 32'h0, 32'h0000_c000, 1'b1);
        // R8: busy ignores and then back-to-back acceptance works
        run(2'd1, 32'h0000_0abc, 32'h0, 32'h0, 32'h0000_0104, 1'b0);
        run(2'd2, 32'h0000_0ac0, 32'h0, 32'h0, 32'h0000_0107, 1'b0);
        // R1: reset in the middle of a trap sequence
        @(negedge clk);
        dec_valid = 1'b1; dec_kind = 2'd1; cur_pc = 32'h55; trap_base = 32'h80;
        @(posedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
        chk(wr_en, "R2 write started before reset", {31'd0, wr_en}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(!wr_en && !done && !busy, "R1 mid-sequence reset", {29'd0, wr_en, done, busy}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !done && !busy, "R1 stays idle after reset", {29'd0, wr_en, done, busy}, 32'd0);
        run(2'd3, 32'h10, 32'h0000_0f0f, 32'h0, 32'h0, 1'b0);
        report();
    end
endmodule